// File: doc/BRIEF.md
# Lockable SMM Memory Window Controller

This block holds one 8-bit configuration control byte and decides where each memory access to the 128 KB legacy system-management window (A0000h to BFFFFh) goes. A simple configuration port reads and writes the byte at one fixed offset. Every access presents an address, a flag saying whether system-management mode is active, and a flag that marks the access as a code fetch or a data reference. The block then routes the access either to local DRAM or to the upstream interface. Nothing is ever remapped or blocked: the window is only shown to DRAM or hidden from it.

Firmware can open the window outside system-management mode to fill it. Later it seals the register with a write-once lock that only a full reset clears. The lock lives in a two-state machine. `LK_OPEN_ST` is the reset state and allows all writable fields to change. `LK_SEALED_ST` is entered by the SEAL transition, which is any configuration write to the offset with the lock bit set. In `LK_SEALED_ST` the global enable, open and lock fields are frozen, and the state is left only through the RESET transition (`rst_n` low). The close bit stays writable in both states.

Register layout, at offset `CFG_OFFSET` (default 9Dh): bit 7 is reserved, bit 6 is open, bit 5 is close, bit 4 is lock, bit 3 is global enable, and bits 2:0 are a fixed base-segment code.

Top module: `smmw_ctrl`

## Requirements
- R1: After reset, a read at the register offset returns 02h, and the lock state is `LK_OPEN_ST`.
- R2: Bits 2:0 always read 010 and bit 7 always reads 0. Writes to these bits are ignored.
- R3: While global enable (bit 3) is 0, no access is routed to DRAM, whatever the open, close, lock and SMM flags are.
- R4: With global enable set, open (bit 6) set and lock clear, an in-window access is routed to DRAM even when the SMM flag is low.
- R5: With global enable and close (bit 5) set, an in-window data access during SMM is forwarded upstream. An in-window code fetch during SMM is still routed to DRAM. `acc_code` is 1 for a code fetch and 0 for a data reference.
- R6: A write with lock (bit 4) set forces open to 0. If a single write sets both open and lock, open reads back 0.
- R7: Once locked, writes do not change global enable, open or lock, but close still follows the written value.
- R8: Lock is sticky: a write of 0 to bit 4 does not clear it, and only reset returns it to 0.
- R9: Every access asserts exactly one of `route_dram` and `route_fwd`. Any access that does not qualify for DRAM is forwarded.
- R10: An access outside A0000h to BFFFFh is never routed to DRAM. Both ends of that range are inside the window.
- R11: A write at any other offset leaves the register unchanged, and a read at any other offset returns 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low full reset |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data (combinational) |
| acc_addr | input | ADDR_W | Access address |
| acc_smm | input | 1 | System-management mode active for this access |
| acc_code | input | 1 | 1 = code fetch, 0 = data reference |
| route_dram | output | 1 | Access goes to local DRAM |
| route_fwd | output | 1 | Access goes to the upstream interface |

## Verification
The hardest situation to reach from the ports is a sealed register that has then taken further writes with mixed bit patterns. Only there do the frozen fields, the still-writable close bit and the decode with open forced to 0 all interact. The random phase therefore lets the lock bit through in a small share of writes, and it pulses reset periodically so that many sealed and unsealed epochs occur. Directed writes also hit the set-open-and-lock-together case, the exact window edges, and writes of zero after sealing.

// File: rtl/smmw_pkg.sv
package smmw_pkg;
    typedef enum logic {
        LK_OPEN_ST   = 1'b0,
        LK_SEALED_ST = 1'b1
    } lock_state_t;

    localparam int BIT_GEN   = 3;
    localparam int BIT_LOCK  = 4;
    localparam int BIT_CLOSE = 5;
    localparam int BIT_OPEN  = 6;
    localparam logic [2:0] BASE_SEG_CODE = 3'b010;

    typedef struct packed {
        logic open;
        logic close;
        logic gen;
    } win_ctl_t;
endpackage

// File: rtl/smmw_lock_fsm.sv
module smmw_lock_fsm
    import smmw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_lock,
    output logic sealed
);
    lock_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LK_OPEN_ST;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_OPEN_ST:   if (wr_en && wr_lock) state_d = LK_SEALED_ST;
            LK_SEALED_ST: state_d = LK_SEALED_ST;
            default:      state_d = LK_OPEN_ST;
        endcase
    end

    always_comb begin
        sealed = (state_q == LK_SEALED_ST);
    end

    // R8: once sealed, only reset leaves the state
    a_r8_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LK_SEALED_ST) |=> (state_q == LK_SEALED_ST));
endmodule

// File: rtl/smmw_cfg_reg.sv
module smmw_cfg_reg
    import smmw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wdata,
    input  logic       sealed,
    output win_ctl_t   ctl
);
    win_ctl_t ctl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (wr_en) begin
            ctl_q.close <= wdata[BIT_CLOSE];
            if (!sealed) begin
                ctl_q.gen  <= wdata[BIT_GEN];
                ctl_q.open <= wdata[BIT_OPEN] & ~wdata[BIT_LOCK];
            end
        end
    end

    assign ctl = ctl_q;

    // R6: a sealed register never shows open
    a_r6_sealed_not_open: assert property (@(posedge clk) disable iff (!rst_n)
        sealed |-> !ctl_q.open);
    // R7: global enable frozen once sealed
    a_r7_gen_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        sealed |=> $stable(ctl_q.gen));
endmodule

// File: rtl/smmw_decode.sv
module smmw_decode
    import smmw_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter logic [ADDR_W-1:0] WIN_BASE = 'hA0000,
    parameter logic [ADDR_W-1:0] WIN_SIZE = 'h20000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              smm,
    input  logic              code,
    input  win_ctl_t          ctl,
    input  logic              sealed,
    output logic              to_dram,
    output logic              to_fwd
);
    localparam logic [ADDR_W-1:0] WIN_LAST = WIN_BASE + WIN_SIZE - 1'b1;

    logic in_win, smm_ok, open_ok;

    always_comb begin
        in_win  = (addr >= WIN_BASE) && (addr <= WIN_LAST);
        smm_ok  = smm && !(ctl.close && !code);
        open_ok = ctl.open && !sealed;
        to_dram = in_win && ctl.gen && (smm_ok || open_ok);
        to_fwd  = !to_dram;
    end

    // R3: disabled window never reaches DRAM
    a_r3_gen_gates: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl.gen |-> !to_dram);
    // R9: exactly one destination
    a_r9_one_dest: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({to_dram, to_fwd}) == 1);
    // R10: outside addresses never go to DRAM
    a_r10_outside_fwd: assert property (@(posedge clk) disable iff (!rst_n)
        ((addr < WIN_BASE) || (addr > WIN_LAST)) |-> !to_dram);
endmodule

// File: rtl/smmw_ctrl.sv
module smmw_ctrl
    import smmw_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter logic [7:0] CFG_OFFSET = 8'h9D,
    parameter logic [ADDR_W-1:0] WIN_BASE = 'hA0000,
    parameter logic [ADDR_W-1:0] WIN_SIZE = 'h20000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        cfg_addr,
    input  logic              cfg_wr,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_smm,
    input  logic              acc_code,
    output logic              route_dram,
    output logic              route_fwd
);
    logic     hit, wr_en, sealed;
    win_ctl_t ctl;

    assign hit   = (cfg_addr == CFG_OFFSET);
    assign wr_en = cfg_wr && hit;

    smmw_lock_fsm u_lock (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_lock (cfg_wdata[BIT_LOCK]),
        .sealed  (sealed)
    );

    smmw_cfg_reg u_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wdata  (cfg_wdata),
        .sealed (sealed),
        .ctl    (ctl)
    );

    smmw_decode #(
        .ADDR_W   (ADDR_W),
        .WIN_BASE (WIN_BASE),
        .WIN_SIZE (WIN_SIZE)
    ) u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (acc_addr),
        .smm     (acc_smm),
        .code    (acc_code),
        .ctl     (ctl),
        .sealed  (sealed),
        .to_dram (route_dram),
        .to_fwd  (route_fwd)
    );

    always_comb begin
        if (hit) cfg_rdata = {1'b0, ctl.open, ctl.close, sealed, ctl.gen, BASE_SEG_CODE};
        else     cfg_rdata = 8'h00;
    end

    // R2: fixed bits never change
    a_r2_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (cfg_rdata[2:0] == 3'b010 && !cfg_rdata[7]));
    // R11: other offsets read as zero
    a_r11_other_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (cfg_rdata == 8'h00));
endmodule

// File: tb/smmw_ctrl_bench.sv
module smmw_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] OFS = 8'h9D;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cfg_addr = OFS;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_wdata = 8'h00;
    logic [7:0]  cfg_rdata;
    logic [31:0] acc_addr = 32'h0;
    logic        acc_smm = 1'b0;
    logic        acc_code = 1'b0;
    logic        route_dram, route_fwd;

    int vectors = 0;
    int miscompares = 0;
    bit m_gen, m_open, m_close, m_lock;

    always #(CLK_PERIOD/2) clk = ~clk;

    smmw_ctrl u_smmw_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_wr(cfg_wr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .acc_addr(acc_addr),
        .acc_smm(acc_smm), .acc_code(acc_code), .route_dram(route_dram),
        .route_fwd(route_fwd)
    );

    function automatic logic [7:0] exp_reg();
        return {1'b0, m_open, m_close, m_lock, m_gen, 3'b010};
    endfunction

    function automatic bit exp_dram(logic [31:0] a, bit smm, bit code);
        bit inw;
        inw = (a >= 32'hA0000) && (a <= 32'hBFFFF);
        return inw && m_gen && ((smm && !(m_close && !code)) || (m_open && !m_lock));
    endfunction

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        vectors++;
        if (got !== exp) begin
            miscompares++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        m_gen = 0; m_open = 0; m_close = 0; m_lock = 0;
    endtask

    task automatic wr(logic [7:0] ofs, logic [7:0] d);
        @(negedge clk);
        cfg_addr = ofs; cfg_wdata = d; cfg_wr = 1'b1;
        @(posedge clk);
        if (ofs == OFS) begin
            m_close = d[5];
            if (!m_lock) begin
                m_gen  = d[3];
                m_open = d[6] & ~d[4];
                m_lock = d[4];
            end
        end
        @(negedge clk);
        cfg_wr = 1'b0; cfg_addr = OFS;
    endtask

    task automatic rd(string req, logic [7:0] ofs, logic [7:0] exp);
        cfg_addr = ofs;
        #1;
        check(req, cfg_rdata, exp);
        cfg_addr = OFS;
    endtask

    task automatic acc(string req, logic [31:0] a, bit smm, bit code);
        bit e;
        acc_addr = a; acc_smm = smm; acc_code = code;
        #1;
        e = exp_dram(a, smm, code);
        check(req, {route_dram, route_fwd}, {e, !e});
    endtask

    function automatic logic [31:0] pick_addr();
        unique case ($urandom % 6)
            0: return 32'hA0000;
            1: return 32'hBFFFF;
            2: return 32'h9FFFF;
            3: return 32'hC0000;
            4: return $urandom;
            default: return 32'hA0000 + ($urandom % 32'h20000);
        endcase
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        miscompares++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        do_reset();
        rd("R1 reset value", OFS, 8'h02);
        // R11: other offset
        wr(8'h9C, 8'hFF);
        rd("R11 other write", OFS, 8'h02);
        rd("R11 other read", 8'h9C, 8'h00);
        // R2: fixed bits
        wr(OFS, 8'h87);
        rd("R2 fixed bits", OFS, 8'h02);
        // R3: open set, enable clear
        wr(OFS, 8'h40);
        acc("R3 gen off no smm", 32'hA8000, 0, 0);
        acc("R3 gen off smm", 32'hA8000, 1, 1);
        // R4 and R10
        wr(OFS, 8'h48);
        acc("R4 open no smm", 32'hB0000, 0, 0);
        acc("R10 low edge", 32'hA0000, 0, 0);
        acc("R10 high edge", 32'hBFFFF, 0, 1);
        acc("R10 below", 32'h9FFFF, 1, 0);
        acc("R10 above", 32'hC0000, 1, 1);
        // R5 close
        wr(OFS, 8'h28);
        acc("R5 data denied", 32'hA1000, 1, 0);
        acc("R5 code allowed", 32'hA1000, 1, 1);
        acc("R9 no smm fwd", 32'hA1000, 0, 1);
        // R6 open and lock together
        wr(OFS, 8'h58);
        rd("R6 lock beats open", OFS, 8'h1A);
        acc("R6 open inert", 32'hA4000, 0, 0);
        // R7 frozen, close writable
        wr(OFS, 8'h60);
        rd("R7 close writable", OFS, 8'h3A);
        wr(OFS, 8'h00);
        rd("R8 lock sticky", OFS, 8'h1A);
        do_reset();
        rd("R8 reset clears", OFS, 8'h02);

        for (int i = 0; i < 3000; i++) begin
            if (i % 500 == 499) do_reset();
            if (($urandom % 4) == 0) begin
                logic [7:0] d;
                d = 8'($urandom);
                if (($urandom % 8) != 0) d[4] = 1'b0;
                wr((($urandom % 8) == 0) ? 8'($urandom) : OFS, d);
                rd("R7 random readback", OFS, exp_reg());
            end
            acc("R9 random decode", pick_addr(), 1'($urandom), 1'($urandom));
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule